// File: doc/BRIEF.md
# Fused multiply-add significand datapath

This block is the finite-operand core of a double-precision fused multiply-add. A front end supplies two normalized 53-bit multiplier significands with their unbiased exponents, one effective product sign, and a normalized 53-bit addend significand with its unbiased exponent, effective sign and a flag that marks the addend as zero. It also supplies a single bit that selects rounding toward minus infinity. The core forms the exact product, aligns product and addend on a shared exponent, adds or subtracts them, and normalizes the result. No rounding happens anywhere inside the block.

The result leaves as a 56-bit significand (53 bits plus guard, round and a sticky bit in the lowest position), an unbiased signed exponent, a sign and an exact-zero flag. A separate rounder consumes this result. The datapath has three register stages: multiply, align and add, then normalize and reduce. The whole pipe advances together under a valid/ready handshake.

Internally every magnitude lives in a 127-bit frame with the leading one at bit 126. Any right shift ORs the bits it discards into bit 0, so no nonzero tail is ever lost.

Top module: `fma_mant_path`

## Requirements
- R1: The product exponent is the sum of the two multiplier exponents, plus one when the significand product is 2 or more. With a zero addend the output significand is the product reduced to 56 bits: the top 55 bits are kept and every lower bit is ORed into bit 0.
- R2: When `add_zero` is 1 the addend significand, exponent and sign have no effect, and the result sign is `prod_sign`.
- R3: The operand with the smaller exponent is shifted right by the exponent difference before the add, with every discarded bit ORed into the frame's bit 0. A difference of 127 or more leaves only that sticky bit.
- R4: With equal signs the magnitudes are added. A carry past the leading position shifts the sum right by one with sticky and raises the exponent by one.
- R5: With differing signs the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger one.
- R6: An exact-zero difference gives `res_zero`=1, `res_sig`=0 and `res_exp`=0. The sign is `round_down`, where 1 means rounding toward minus infinity.
- R7: A nonzero result has `res_sig[55]`=1. After a cancellation the exponent is lowered by the left-shift distance.
- R8: Results leave in acceptance order. While `out_valid` is high and `out_ready` is low, all outputs hold. `in_ready` equals `!out_valid || out_ready`.
- R9: While reset is applied, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set taken on this edge |
| mul_a_sig | input | 53 | First multiplier significand, bit 52 set |
| mul_a_exp | input | 14 | First multiplier unbiased exponent, signed |
| mul_b_sig | input | 53 | Second multiplier significand, bit 52 set |
| mul_b_exp | input | 14 | Second multiplier unbiased exponent, signed |
| prod_sign | input | 1 | Effective product sign |
| add_sig | input | 53 | Addend significand, bit 52 set when nonzero |
| add_exp | input | 14 | Addend unbiased exponent, signed |
| add_sign | input | 1 | Effective addend sign |
| add_zero | input | 1 | Addend is zero |
| round_down | input | 1 | Rounding toward minus infinity selected |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | 14 | Result unbiased exponent, signed |
| res_sig | output | 56 | Result significand with three low rounding bits |
| res_zero | output | 1 | Result is exactly zero |

## Verification
A zero addend with junk on the addend fields isolates the multiply and its one-bit renormalization from the adder. Addends whose exponents lie within a few places of the product, with random signs, separate true addition from subtraction and expose carry-out. Exponent gaps far beyond the frame width test that the sticky bit survives alignment on either side. Addends built by flipping a few low bits of the product, with opposite sign, force deep cancellation and exact zeros under both rounding selections. A phase with random `out_ready` stalls shows whether results stay ordered and held.

// File: rtl/fma_pkg.sv
`timescale 1ns/1ps
package fma_pkg;
    localparam int SIG_W   = 53;
    localparam int GRD_W   = 3;
    localparam int EXP_W   = 14;
    localparam int JUST_W  = 64;
    localparam int FRAME_W = 2 * JUST_W;
    localparam int MAG_W   = FRAME_W - 1;
    localparam int LEAD    = MAG_W - 1;
    localparam int PAD_W   = JUST_W - SIG_W;
    localparam int ADD_PAD = MAG_W - SIG_W;
    localparam int OUT_W   = SIG_W + GRD_W;
    localparam int RED_SH  = LEAD - (OUT_W - 1);
    localparam int LZ_W    = $clog2(MAG_W);
    localparam int SH_W    = EXP_W + 1;

    typedef logic [MAG_W-1:0]        mag_t;
    typedef logic signed [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic             valid;
        logic             p_sign;
        exp_t             p_exp;
        mag_t             p_mag;
        logic [SIG_W-1:0] z_sig;
        exp_t             z_exp;
        logic             z_sign;
        logic             z_zero;
        logic             rnd_dn;
    } mul_stg_t;

    typedef struct packed {
        logic valid;
        logic sign;
        exp_t exp;
        mag_t mag;
        logic zero;
    } sum_stg_t;

    typedef struct packed {
        logic             valid;
        logic             sign;
        exp_t             exp;
        logic [OUT_W-1:0] sig;
        logic             zero;
    } out_stg_t;

    typedef struct packed {
        mul_stg_t m;
        sum_stg_t s;
        out_stg_t o;
    } pipe_t;

    // Right shift that folds every discarded bit into bit 0.
    function automatic mag_t jam_shift(input mag_t v, input logic [SH_W-1:0] amt);
        mag_t lost;
        mag_t r;
        if (amt >= SH_W'(MAG_W)) begin
            r    = '0;
            r[0] = |v;
        end else begin
            lost = ~({MAG_W{1'b1}} << amt);
            r    = v >> amt;
            r[0] = r[0] | (|(v & lost));
        end
        return r;
    endfunction
endpackage

// File: rtl/fma_sig_mul.sv
`timescale 1ns/1ps
module fma_sig_mul
    import fma_pkg::*;
(
    input  logic [SIG_W-1:0] a_sig,
    input  exp_t             a_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  exp_t             b_exp,
    output mag_t             p_mag,
    output exp_t             p_exp
);
    logic [JUST_W-1:0]  ja;
    logic [JUST_W-1:0]  jb;
    logic [FRAME_W-1:0] raw;

    always_comb begin
        ja  = {a_sig, {PAD_W{1'b0}}};
        jb  = {b_sig, {PAD_W{1'b0}}};
        raw = FRAME_W'(ja) * FRAME_W'(jb);
        // Leading one lands at the top bit or one below; pin it one below.
        if (raw[FRAME_W-1]) begin
            p_mag = {raw[FRAME_W-1:2], raw[1] | raw[0]};
        end else begin
            p_mag = raw[MAG_W-1:0];
        end
        p_exp = a_exp + b_exp + EXP_W'(raw[FRAME_W-1]);
    end
endmodule

// File: rtl/fma_align_add.sv
`timescale 1ns/1ps
module fma_align_add
    import fma_pkg::*;
(
    input  mag_t             p_mag,
    input  exp_t             p_exp,
    input  logic             p_sign,
    input  logic [SIG_W-1:0] z_sig,
    input  exp_t             z_exp,
    input  logic             z_sign,
    input  logic             z_zero,
    input  logic             rnd_dn,
    output mag_t             r_mag,
    output exp_t             r_exp,
    output logic             r_sign,
    output logic             r_zero
);
    mag_t                   z_mag;
    mag_t                   p_al;
    mag_t                   z_al;
    mag_t                   dif;
    exp_t                   base_exp;
    logic signed [SH_W-1:0] ediff;
    logic                   z_ahead;
    logic                   z_big;
    logic [FRAME_W-1:0]     sum;

    always_comb begin
        z_mag    = {z_sig, {ADD_PAD{1'b0}}};
        ediff    = {z_exp[EXP_W-1], z_exp} - {p_exp[EXP_W-1], p_exp};
        z_ahead  = !ediff[SH_W-1] && (ediff != '0);
        p_al     = p_mag;
        z_al     = z_mag;
        base_exp = p_exp;
        if (z_ahead) begin
            p_al     = jam_shift(p_mag, ediff);
            base_exp = z_exp;
        end else if (ediff[SH_W-1]) begin
            z_al = jam_shift(z_mag, -ediff);
        end

        sum   = {1'b0, z_al} + {1'b0, p_al};
        z_big = (z_al >= p_al);
        dif   = z_big ? (z_al - p_al) : (p_al - z_al);

        if (z_zero) begin
            r_mag  = p_mag;
            r_exp  = p_exp;
            r_sign = p_sign;
            r_zero = 1'b0;
        end else if (z_sign == p_sign) begin
            r_mag  = sum[FRAME_W-1] ? {sum[FRAME_W-1:2], sum[1] | sum[0]} : sum[MAG_W-1:0];
            r_exp  = base_exp + EXP_W'(sum[FRAME_W-1]);
            r_sign = p_sign;
            r_zero = 1'b0;
        end else if (dif == '0) begin
            r_mag  = '0;
            r_exp  = '0;
            r_sign = rnd_dn;
            r_zero = 1'b1;
        end else begin
            r_mag  = dif;
            r_exp  = base_exp;
            r_sign = z_big ? z_sign : p_sign;
            r_zero = 1'b0;
        end
    end
endmodule

// File: rtl/fma_norm_reduce.sv
`timescale 1ns/1ps
module fma_norm_reduce
    import fma_pkg::*;
(
    input  mag_t             mag,
    input  exp_t             exp_i,
    input  logic             sign_i,
    input  logic             zero_i,
    output logic [OUT_W-1:0] sig_o,
    output exp_t             exp_o,
    output logic             sign_o,
    output logic             zero_o
);
    logic [LZ_W-1:0] lz;
    mag_t            shifted;

    always_comb begin
        lz = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) lz = LZ_W'(LEAD - i);
        end
        shifted = mag << lz;
        sign_o  = sign_i;
        zero_o  = zero_i;
        if (zero_i) begin
            sig_o = '0;
            exp_o = '0;
        end else begin
            sig_o = {shifted[LEAD -: OUT_W-1], |shifted[RED_SH:0]};
            exp_o = exp_i - EXP_W'(lz);
        end
    end
endmodule

// File: rtl/fma_mant_path.sv
`timescale 1ns/1ps
module fma_mant_path
    import fma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [52:0]             mul_a_sig,
    input  logic signed [13:0]      mul_a_exp,
    input  logic [52:0]             mul_b_sig,
    input  logic signed [13:0]      mul_b_exp,
    input  logic                    prod_sign,
    input  logic [52:0]             add_sig,
    input  logic signed [13:0]      add_exp,
    input  logic                    add_sign,
    input  logic                    add_zero,
    input  logic                    round_down,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    res_sign,
    output logic signed [13:0]      res_exp,
    output logic [55:0]             res_sig,
    output logic                    res_zero
);
    pipe_t pipe_d;
    pipe_t pipe_q;

    mag_t             mul_mag;
    exp_t             mul_exp;
    mag_t             sum_mag;
    exp_t             sum_exp;
    logic             sum_sign;
    logic             sum_zero;
    logic [OUT_W-1:0] nrm_sig;
    exp_t             nrm_exp;
    logic             nrm_sign;
    logic             nrm_zero;

    fma_sig_mul u_mul (
        .a_sig (mul_a_sig),
        .a_exp (mul_a_exp),
        .b_sig (mul_b_sig),
        .b_exp (mul_b_exp),
        .p_mag (mul_mag),
        .p_exp (mul_exp)
    );

    fma_align_add u_add (
        .p_mag  (pipe_q.m.p_mag),
        .p_exp  (pipe_q.m.p_exp),
        .p_sign (pipe_q.m.p_sign),
        .z_sig  (pipe_q.m.z_sig),
        .z_exp  (pipe_q.m.z_exp),
        .z_sign (pipe_q.m.z_sign),
        .z_zero (pipe_q.m.z_zero),
        .rnd_dn (pipe_q.m.rnd_dn),
        .r_mag  (sum_mag),
        .r_exp  (sum_exp),
        .r_sign (sum_sign),
        .r_zero (sum_zero)
    );

    fma_norm_reduce u_nrm (
        .mag    (pipe_q.s.mag),
        .exp_i  (pipe_q.s.exp),
        .sign_i (pipe_q.s.sign),
        .zero_i (pipe_q.s.zero),
        .sig_o  (nrm_sig),
        .exp_o  (nrm_exp),
        .sign_o (nrm_sign),
        .zero_o (nrm_zero)
    );

    assign in_ready = !pipe_q.o.valid || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (in_ready) begin
            pipe_d.m.valid  = in_valid;
            pipe_d.m.p_sign = prod_sign;
            pipe_d.m.p_exp  = mul_exp;
            pipe_d.m.p_mag  = mul_mag;
            pipe_d.m.z_sig  = add_sig;
            pipe_d.m.z_exp  = add_exp;
            pipe_d.m.z_sign = add_sign;
            pipe_d.m.z_zero = add_zero;
            pipe_d.m.rnd_dn = round_down;

            pipe_d.s.valid  = pipe_q.m.valid;
            pipe_d.s.sign   = sum_sign;
            pipe_d.s.exp    = sum_exp;
            pipe_d.s.mag    = sum_mag;
            pipe_d.s.zero   = sum_zero;

            pipe_d.o.valid  = pipe_q.s.valid;
            pipe_d.o.sign   = nrm_sign;
            pipe_d.o.exp    = nrm_exp;
            pipe_d.o.sig    = nrm_sig;
            pipe_d.o.zero   = nrm_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.o.valid;
    assign res_sign  = pipe_q.o.sign;
    assign res_exp   = pipe_q.o.exp;
    assign res_sig   = pipe_q.o.sig;
    assign res_zero  = pipe_q.o.zero;

    // R1: the registered product always carries its leading one at the frame lead.
    a_r1_prod_lead: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.m.valid |-> pipe_q.m.p_mag[LEAD]);

    // R5: a difference not flagged zero is a nonzero magnitude.
    a_r5_nonzero_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s.valid && !pipe_q.s.zero) |-> (pipe_q.s.mag != '0));

    // R6: an exact zero leaves with a clean significand and exponent.
    a_r6_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_zero) |-> (res_sig == '0 && res_exp == '0));

    // R7: every nonzero result is normalized.
    a_r7_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_zero) |-> res_sig[OUT_W-1]);

    // R8: a stalled result holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_sig) && $stable(res_exp)
                                       && $stable(res_sign) && $stable(res_zero)));
endmodule

// File: tb/fma_mant_path_bench.sv
`timescale 1ns/1ps
module fma_mant_path_bench;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic               in_ready;
    logic [52:0]        mul_a_sig, mul_b_sig, add_sig;
    logic signed [13:0] mul_a_exp, mul_b_exp, add_exp;
    logic               prod_sign, add_sign, add_zero, round_down;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic               res_sign;
    logic signed [13:0] res_exp;
    logic [55:0]        res_sig;
    logic               res_zero;

    always #10 clk = ~clk;

    fma_mant_path u_fma_mant_path (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mul_a_sig(mul_a_sig), .mul_a_exp(mul_a_exp),
        .mul_b_sig(mul_b_sig), .mul_b_exp(mul_b_exp), .prod_sign(prod_sign),
        .add_sig(add_sig), .add_exp(add_exp), .add_sign(add_sign),
        .add_zero(add_zero), .round_down(round_down),
        .out_valid(out_valid), .out_ready(out_ready),
        .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig), .res_zero(res_zero)
    );

    typedef struct {
        bit        s;
        int        e;
        bit [55:0] m;
        bit        z;
    } want_t;

    want_t eq [0:2047];
    string tq [0:2047];
    int    wr = 0;
    int    rd = 0;
    int    checks = 0;
    int    errors = 0;
    bit    stall_mode = 1'b0;

    localparam bit [52:0] ONE  = 53'h10000000000000;
    localparam bit [52:0] ONEH = 53'h18000000000000;
    localparam bit [52:0] ONEU = 53'h10000000000001;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic bit [126:0] jam_shr(input bit [126:0] v, input int n);
        bit [126:0] t = v;
        for (int k = 0; k < n && k < 130; k++) begin
            bit lo = t[0];
            t = t >> 1;
            t[0] = t[0] | lo;
        end
        return t;
    endfunction

    function automatic want_t model(input bit [52:0] a, input bit [52:0] b, input int ea, input int eb,
                                    input bit ps, input bit [52:0] z, input int ez, input bit zs,
                                    input bit zz, input bit rdn);
        bit [127:0] p;
        bit [126:0] f;
        bit [126:0] g;
        bit [127:0] s;
        int         e;
        want_t      r;
        p = 128'(a) * 128'(b);
        e = ea + eb;
        if (p[105]) begin
            f = 127'(p) << 21;
            e++;
        end else begin
            f = 127'(p) << 22;
        end
        r.s = ps;
        r.z = 1'b0;
        if (!zz) begin
            g = 127'(z) << 74;
            if (ez > e) begin
                f = jam_shr(f, ez - e);
                e = ez;
            end else if (e > ez) begin
                g = jam_shr(g, e - ez);
            end
            if (zs == ps) begin
                s = {1'b0, f} + {1'b0, g};
                if (s[127]) begin
                    f = s[127:1];
                    f[0] = f[0] | s[0];
                    e++;
                end else begin
                    f = s[126:0];
                end
            end else begin
                if (g >= f) begin
                    f = g - f;
                    r.s = zs;
                end else begin
                    f = f - g;
                    r.s = ps;
                end
                if (f == '0) begin
                    r.z = 1'b1;
                    r.s = rdn;
                    r.e = 0;
                    r.m = '0;
                    return r;
                end
                while (!f[126]) begin
                    f = f << 1;
                    e--;
                end
            end
        end
        f   = jam_shr(f, 71);
        r.m = f[55:0];
        r.e = e;
        return r;
    endfunction

    task automatic send(input bit [52:0] a, input bit [52:0] b, input int ea, input int eb,
                        input bit ps, input bit [52:0] z, input int ez, input bit zs,
                        input bit zz, input bit rdn, input string tag);
        @(negedge clk);
        mul_a_sig  = a;
        mul_b_sig  = b;
        mul_a_exp  = 14'(ea);
        mul_b_exp  = 14'(eb);
        prod_sign  = ps;
        add_sig    = z;
        add_exp    = 14'(ez);
        add_sign   = zs;
        add_zero   = zz;
        round_down = rdn;
        in_valid   = 1'b1;
        while (!in_ready) @(negedge clk);
        eq[wr] = model(a, b, ea, eb, ps, z, ez, zs, zz, rdn);
        tq[wr] = tag;
        wr++;
    endtask

    function automatic bit [52:0] rsig();
        return {1'b1, $urandom(), 20'($urandom())};
    endfunction

    always @(posedge clk) begin
        #1;
        out_ready = stall_mode ? ($urandom_range(2) != 0) : 1'b1;
    end

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                check(in_ready == (!out_valid || out_ready), "R8",
                      $sformatf("in_ready got %0d exp %0d", in_ready, !out_valid || out_ready));
                if (out_valid && out_ready) begin
                    if (rd >= wr) begin
                        check(1'b0, "R8", "result with none outstanding got 1 exp 0");
                    end else begin
                        want_t w = eq[rd];
                        bit ok = (res_sign == w.s) && (int'(res_exp) == w.e) &&
                                 (res_sig == w.m) && (res_zero == w.z);
                        check(ok, tq[rd], $sformatf(
                            "#%0d got s=%0d e=%0d m=%h z=%0d exp s=%0d e=%0d m=%h z=%0d",
                            rd, res_sign, res_exp, res_sig, res_zero, w.s, w.e, w.m, w.z));
                        if (!res_zero)
                            check(res_sig[55], "R7", $sformatf("lead bit got %0d exp 1", res_sig[55]));
                        rd++;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang exp completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231028));
        rst_n = 1'b0;
        in_valid = 1'b0;
        mul_a_sig = '0; mul_b_sig = '0; add_sig = '0;
        mul_a_exp = '0; mul_b_exp = '0; add_exp = '0;
        prod_sign = 1'b0; add_sign = 1'b0; add_zero = 1'b0; round_down = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", $sformatf("out_valid in reset got %0d exp 0", out_valid));
        check(in_ready == 1'b1, "R9", $sformatf("in_ready in reset got %0d exp 1", in_ready));
        rst_n = 1'b1;

        // Directed corners
        send(ONEH, ONEH, 3, -5, 1'b0, ONE, 0, 1'b0, 1'b1, 1'b0, "R1");
        send(ONE, ONEU, 10, 20, 1'b1, ONE, 0, 1'b0, 1'b1, 1'b0, "R1");
        send(ONEH, ONEH, 3, -5, 1'b1, rsig(), 700, 1'b0, 1'b1, 1'b1, "R2");
        send(ONE, ONE, 0, 0, 1'b0, ONE, 0, 1'b1, 1'b0, 1'b0, "R6");
        send(ONE, ONE, 0, 0, 1'b0, ONE, 0, 1'b1, 1'b0, 1'b1, "R6");
        send(ONE, ONE, 0, 0, 1'b1, ONE, 0, 1'b1, 1'b0, 1'b0, "R4");
        send(ONE, ONE, 0, 0, 1'b0, ONEH, 200, 1'b0, 1'b0, 1'b0, "R3");
        send(ONE, ONE, 150, 150, 1'b1, ONEH, 0, 1'b0, 1'b0, 1'b0, "R3");
        send(ONE, ONEU, 0, 0, 1'b0, ONE, 0, 1'b1, 1'b0, 1'b0, "R7");
        send(ONE, ONE, 0, 0, 1'b0, ONEH, 0, 1'b1, 1'b0, 1'b0, "R5");
        send(ONE, ONE, 0, 1, 1'b1, ONEH, 0, 1'b0, 1'b0, 1'b0, "R5");
        send(ONE, ONE, 0, 0, 1'b0, ONE, 60, 1'b1, 1'b0, 1'b0, "R3");

        // Random mix, then the same with output stalls
        for (int phase = 0; phase < 2; phase++) begin
            stall_mode = (phase == 1);
            for (int n = 0; n < 300; n++) begin
                bit [52:0] a = rsig();
                bit [52:0] b = rsig();
                int ea = int'($urandom_range(2000)) - 1000;
                int eb = int'($urandom_range(2000)) - 1000;
                int kind = int'($urandom_range(4));
                bit ps = 1'($urandom());
                bit zs = 1'($urandom());
                bit rdn = 1'($urandom());
                string tag = stall_mode ? "R8" : "R5";
                case (kind)
                    0: send(a, b, ea, eb, ps, rsig(), ea + eb + int'($urandom_range(8)) - 4,
                            zs, 1'b0, rdn, stall_mode ? "R8" : "R4");
                    1: send(a, b, ea, eb, ps, rsig(), ea + eb + int'($urandom_range(400)) - 200,
                            zs, 1'b0, rdn, stall_mode ? "R8" : "R3");
                    2: send(a, b, ea, eb, ps, rsig(), int'($urandom_range(2000)) - 1000,
                            zs, 1'b1, rdn, stall_mode ? "R8" : "R2");
                    default: send(a, ONE, ea, 0, ps,
                                  {1'b1, a[51:0] ^ 52'($urandom_range(3) == 0 ? 0 : $urandom_range(255))},
                                  ea, ~ps, 1'b0, rdn, tag);
                endcase
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (rd < wr) @(negedge clk);
        stall_mode = 1'b0;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R8", $sformatf("idle out_valid got %0d exp 0", out_valid));
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule